// File: doc/BRIEF.md
# Bit Field Manipulation Unit

This unit performs one operation on a contiguous group of bits inside a 16-bit word. A compact descriptor gives the field: a width code and an offset, both packed into the low byte of a 16-bit descriptor operand. The same mask drives five operations. Extract pulls the field out of a source word and right-aligns it. Insert writes the low bits of the source into the field of a destination word. Clear, set and toggle change only the field bits of the destination.

A caller puts the operands and an operation code on the inputs and raises `start` for one cycle. On the next cycle the registered result, its zero and negative flags, and a one-cycle `done` pulse appear. The result and flags then hold until the next start. A field that runs past the top of the word is cut off at bit 15.

Top module: `bfu_unit`

## Requirements
- R1: The field comes only from descriptor bits 7:0. The width code is bits 7:4 and the offset is bits 3:0. Bits 15:8 of the descriptor have no effect on any output.
- R2: The field length is the width code plus one, so code 0 selects one bit and code 15 selects sixteen bits. Offset 0 puts the field's lowest bit at word bit 0, and each larger offset moves it one place toward bit 15.
- R3: Extract (op 0) returns source bits [offset+len-1:offset] in result bits [len-1:0], and every result bit from len upward is 0. For example, width code 3 with offset 2 returns source bits 5:2 in result bits 3:0.
- R4: Insert (op 1) puts source bits [len-1:0] into the field of the destination. Every destination bit outside the field passes to the result unchanged.
- R5: Clear (op 2) makes the field bits 0, set (op 3) makes them 1, and toggle (op 4) inverts them. All other bits equal the destination.
- R6: When offset plus length is more than 16, the field bits that would fall above bit 15 are dropped. Only bits up to 15 are changed, and extract returns only the source bits that exist.
- R7: Op codes 5, 6 and 7 return the destination word unchanged.
- R8: The result and flags are updated on the clock edge where `start` is high, so they are visible one cycle after start. `done` is high for exactly that one cycle. Without a start, the result holds.
- R9: After an operation, `zero` is 1 exactly when the result is all zeros, and `neg` equals result bit 15.
- R10: A synchronous active-high reset clears `result`, `zero`, `neg` and `done` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation with the present operands |
| op | input | 3 | Operation: 0 extract, 1 insert, 2 clear, 3 set, 4 toggle, 5-7 pass destination |
| src | input | 16 | Source word |
| dst | input | 16 | Destination word |
| desc | input | 16 | Descriptor: width code in bits 7:4, offset in bits 3:0, bits 15:8 unused |
| result | output | 16 | Registered result |
| zero | output | 1 | Result is all zeros |
| neg | output | 1 | Result bit 15 |
| done | output | 1 | One-cycle pulse, result valid |

## Verification
The hardest case to reach is a field that crosses the top of the word while the descriptor's high byte carries unrelated bits. In that case the truncated mask and the ignored byte must both behave. The bench sweeps all 256 width and offset pairs for all eight op codes and three data patterns. It fills the descriptor's high byte with pseudo-random bits, so every overflowing field is reached under varying upper-byte values. The all-ones and all-zeros patterns force zero and negative results so that the flags are exercised.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam logic [2:0] OP_EXTRACT = 3'd0;
  localparam logic [2:0] OP_INSERT  = 3'd1;
  localparam logic [2:0] OP_CLEAR   = 3'd2;
  localparam logic [2:0] OP_SET     = 3'd3;
  localparam logic [2:0] OP_TOGGLE  = 3'd4;
endpackage

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen #(
  parameter int DATA_W = 16,
  parameter int CODE_W = $clog2(DATA_W)
) (
  input  logic [CODE_W-1:0] width_code,
  input  logic [CODE_W-1:0] offset,
  output logic [DATA_W-1:0] low_mask,
  output logic [DATA_W-1:0] field_mask
);
  // Bit i of the low mask is set when i is below the field length (code + 1).
  for (genvar i = 0; i < DATA_W; i++) begin : g_low
    assign low_mask[i] = (width_code >= CODE_W'(i));
  end

  // Shifting left drops any field bits that would land past the top bit.
  assign field_mask = low_mask << offset;
endmodule

// File: rtl/bfu_field_alu.sv
module bfu_field_alu
  import bfu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CODE_W = $clog2(DATA_W)
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  input  logic [CODE_W-1:0] offset,
  input  logic [DATA_W-1:0] low_mask,
  input  logic [DATA_W-1:0] field_mask,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    case (op)
      OP_EXTRACT: res = (src >> offset) & low_mask;
      OP_INSERT:  res = (dst & ~field_mask) | ((src << offset) & field_mask);
      OP_CLEAR:   res = dst & ~field_mask;
      OP_SET:     res = dst | field_mask;
      OP_TOGGLE:  res = dst ^ field_mask;
      default:    res = dst;
    endcase
  end

  always_comb begin
    if (op == OP_EXTRACT) begin
      a_r3_zero_fill: assert ((res & ~low_mask) == '0);
    end
    if (op >= OP_INSERT && op <= OP_TOGGLE) begin
      // R4, R5: bits outside the field follow the destination
      a_r5_outside_kept: assert ((res & ~field_mask) == (dst & ~field_mask));
    end
  end
endmodule

// File: rtl/bfu_unit.sv
module bfu_unit #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] desc,
  output logic [DATA_W-1:0] result,
  output logic              zero,
  output logic              neg,
  output logic              done
);
  localparam int CODE_W = $clog2(DATA_W);
  localparam int DESC_USED = 2 * CODE_W;

  logic [CODE_W-1:0] width_code;
  logic [CODE_W-1:0] offset;
  logic [DATA_W-1:0] low_mask;
  logic [DATA_W-1:0] field_mask;
  logic [DATA_W-1:0] alu_res;
  logic              unused_desc_hi;

  assign width_code     = desc[DESC_USED-1:CODE_W];
  assign offset         = desc[CODE_W-1:0];
  assign unused_desc_hi = ^desc[DATA_W-1:DESC_USED];

  bfu_mask_gen #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_mask (
    .width_code (width_code),
    .offset     (offset),
    .low_mask   (low_mask),
    .field_mask (field_mask)
  );

  bfu_field_alu #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_alu (
    .op         (op),
    .src        (src),
    .dst        (dst),
    .offset     (offset),
    .low_mask   (low_mask),
    .field_mask (field_mask),
    .res        (alu_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      zero   <= 1'b0;
      neg    <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        result <= alu_res;
        zero   <= (alu_res == '0);
        neg    <= alu_res[DATA_W-1];
      end
    end
  end

  a_r8_done_after_start: assert property (@(posedge clk) disable iff (rst)
    start |=> done);
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done);
  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(result));
  a_r9_zero_flag: assert property (@(posedge clk) disable iff (rst)
    done |-> (zero == (result == '0)));
  a_r9_neg_flag: assert property (@(posedge clk) disable iff (rst)
    done |-> (neg == result[DATA_W-1]));
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (result == '0 && !zero && !neg && !done));
endmodule

// File: tb/bfu_unit_test.sv
module bfu_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [15:0] src = '0, dst = '0, desc = '0;
  logic [15:0] result;
  logic        zero, neg, done;

  int checks = 0;
  int fails  = 0;
  logic [31:0] rng = 32'h1234_5678;

  bfu_unit #(.DATA_W(16)) uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .src(src), .dst(dst),
    .desc(desc), .result(result), .zero(zero), .neg(neg), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic [15:0] model(input logic [2:0] o, input logic [15:0] s,
                                        input logic [15:0] d, input logic [15:0] ds);
    logic [15:0] r;
    int len, off;
    len = int'(ds[7:4]) + 1;
    off = int'(ds[3:0]);
    for (int b = 0; b < 16; b++) begin
      bit inf;
      inf = (b >= off) && (b < off + len);
      r[b] = d[b];
      case (o)
        3'd0: begin
          r[b] = 1'b0;
          if (b < len && b + off < 16) r[b] = s[b + off];
        end
        3'd1: if (inf) r[b] = s[b - off];
        3'd2: if (inf) r[b] = 1'b0;
        3'd3: if (inf) r[b] = 1'b1;
        3'd4: if (inf) r[b] = ~d[b];
        default: ;
      endcase
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] o, input logic [15:0] s,
                        input logic [15:0] d, input logic [15:0] ds,
                        output logic [15:0] got);
    @(negedge clk);
    op = o; src = s; dst = d; desc = ds; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = result;
  endtask

  task automatic run_vec(input logic [2:0] o, input logic [15:0] s,
                         input logic [15:0] d, input logic [15:0] ds);
    logic [15:0] exp, got;
    string tag;
    exp = model(o, s, d, ds);
    if (int'(ds[7:4]) + 1 + int'(ds[3:0]) > 16) tag = "R6";
    else if (o == 3'd0) tag = "R3";
    else if (o == 3'd1) tag = "R4";
    else if (o <= 3'd4) tag = "R5";
    else tag = "R7";
    run_op(o, s, d, ds, got);
    check(got === exp, tag, got, exp);
    check(done === 1'b1, "R8 done", {15'd0, done}, 16'd1);
    check(zero === (exp == 16'd0), "R9 zero", {15'd0, zero}, {15'd0, exp == 16'd0});
    check(neg === exp[15], "R9 neg", {15'd0, neg}, {15'd0, exp[15]});
    // Idle cycle: done drops, result holds, upper inputs changed (R8)
    op = ~o; src = ~s; dst = ~d;
    @(negedge clk);
    check(done === 1'b0, "R8 pulse", {15'd0, done}, 16'd0);
    check(result === exp, "R8 hold", result, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] g1, g2;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(result === 16'd0 && !zero && !neg && !done, "R10 reset", result, 16'd0);
    rst = 1'b0;

    // R2: single bit and full word
    run_op(3'd0, 16'hFFFF, 16'h0, 16'h0000, g1);
    check(g1 === 16'h0001, "R2 width0", g1, 16'h0001);
    run_op(3'd0, 16'hFFFF, 16'h0, 16'h00F0, g1);
    check(g1 === 16'hFFFF, "R2 width15", g1, 16'hFFFF);
    run_op(3'd3, 16'h0, 16'h0, 16'h0005, g1);
    check(g1 === 16'h0020, "R2 offset5", g1, 16'h0020);

    // R3: width code 3, offset 2 example
    run_op(3'd0, 16'b0000_0000_0011_0100, 16'hFFFF, 16'h0032, g1);
    check(g1 === 16'h000D, "R3 example", g1, 16'h000D);

    // R1: high byte of descriptor ignored
    run_op(3'd1, 16'hA5C3, 16'h1234, 16'h0037, g1);
    run_op(3'd1, 16'hA5C3, 16'h1234, 16'hFF37, g2);
    check(g1 === g2, "R1 high byte", g2, g1);
    check(g1 === model(3'd1, 16'hA5C3, 16'h1234, 16'h0037), "R1 low byte", g1,
          model(3'd1, 16'hA5C3, 16'h1234, 16'h0037));

    // Full sweep of op, width, offset over three data patterns
    for (int p = 0; p < 3; p++) begin
      for (int o = 0; o < 8; o++) begin
        for (int w = 0; w < 16; w++) begin
          for (int f = 0; f < 16; f++) begin
            logic [15:0] s, d, ds;
            rng = next_rng(rng);
            ds = {rng[31:24], 4'(w), 4'(f)};
            if (p == 0) begin
              s = rng[15:0];
              rng = next_rng(rng);
              d = rng[15:0];
            end else if (p == 1) begin
              s = 16'hFFFF; d = 16'h0000;
            end else begin
              s = 16'h0000; d = 16'hFFFF;
            end
            run_vec(3'(o), s, d, ds);
          end
        end
      end
    end

    // R10: reset clears a nonzero result
    run_op(3'd3, 16'h0, 16'h0, 16'h00F0, g1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(result === 16'd0 && !zero && !neg && !done, "R10 mid reset", result, 16'd0);
    rst = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule